// File: doc/BRIEF.md
# Flash Segment Window Decoder

This block keeps one segment register for each flash chip select. A segment register marks where that chip's window begins and ends inside a fixed flash address window. All boundaries are counted in 8 MB units. Software writes these registers. The block checks each write: it rejects a window that lies outside the flash window, pins the start of chip select 0 to the window base, and flags windows that are misaligned or that overlap another chip select's window. Flagged windows are still stored.

The block also serves memory accesses through one decode port that has two modes. In window mode, a flash-window address is mapped to the lowest-numbered chip select whose segment contains it, together with the byte offset inside that segment. In direct mode, the caller names the chip select and gives an offset inside it. An offset past the end of that segment is wrapped by a mask and flagged. Segment sizes are meant to be powers of two, so the wrap needs no divider. Register reads, write results and decode results all appear one clock after the request.

Top module: `seg_window_decoder`

## Requirements
- R1: The segment register layout is as follows. Bits [31:24] hold the end unit and bits [23:16] hold the start unit; a unit is address bits [30:23]. Bits [15:0] are dropped on write and always read as zero.
- R2: A write to chip select 0 stores the window base unit as its start, whatever start value the write carried.
- R3: A write is rejected when its end unit is at or below the base unit, or when its start unit is above base plus window units. A rejected write leaves the register unchanged and pulses wr_reject with no other flag.
- R4: The size is end minus start in units, or zero when end is not above start. A non-zero size that is not a power of two, or a start that is not a multiple of the size, pulses wr_align_err. The value is still stored.
- R5: A window that intersects the window of any other existing chip select pulses wr_overlap_err. The value is still stored.
- R6: A write whose bits [31:16] equal the stored register does nothing and raises no flag. Write flags pulse only in the cycle after a write.
- R7: A direct-mode access at offset at or beyond the segment size raises dec_out_range. The returned offset is the input masked by size minus one, or zero for an empty segment. Window-mode results never raise dec_out_range.
- R8: After reset, chip select 0 spans CS0_UNITS units starting at the base. Each later chip select follows the previous one with CSN_UNITS units. With the defaults, the five registers read 0x48400000, 0x4C480000, 0x504C0000, 0x54500000 and 0x58540000.
- R9: A window-mode access returns the lowest-numbered chip select whose range [start, end) contains the address unit. The offset is the address minus the start address. The result appears one cycle after dec_valid.
- R10: A window-mode address that no segment contains, or a direct-mode access naming a nonexistent chip select, raises dec_out_miss with chip select 0 and offset 0.
- R11: Writes to a nonexistent chip select index change nothing and raise no flag. Reads of such an index return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Segment register write strobe |
| reg_wr_cs | input | CS_W (3) | Chip select index of the write |
| reg_wr_data | input | 32 | Write value |
| reg_rd_cs | input | CS_W (3) | Chip select index to read |
| reg_rd_data | output | 32 | Registered read value |
| wr_reject | output | 1 | Write refused as outside the flash window |
| wr_align_err | output | 1 | Stored window is misaligned or not a power of two in size |
| wr_overlap_err | output | 1 | Stored window overlaps another chip select |
| dec_valid | input | 1 | Decode request |
| dec_direct | input | 1 | 1: direct mode using dec_cs; 0: window mode |
| dec_cs | input | CS_W (3) | Chip select for direct mode |
| dec_addr | input | 31 | Window address (window mode) or offset (direct mode) |
| dec_out_valid | output | 1 | Decode result valid |
| dec_out_cs | output | CS_W (3) | Selected chip select |
| dec_out_offset | output | 31 | Offset within the segment |
| dec_out_miss | output | 1 | No segment matched |
| dec_out_range | output | 1 | Direct offset was out of range and wrapped |

## Verification
The assertions check the following on every cycle:
- the zero low half of read data, and the pinned start of chip select 0 on any read;
- that a rejection never comes with another flag, and that flags appear only after a write;
- the one-cycle decode latency, the zeroed result on a miss, and that no window-mode result is ever flagged out of range.

Only the bench scenarios can show the checks that depend on which register values were written:
- that rejected or repeated writes leave the contents unchanged;
- that alignment and overlap are judged against the actual neighbours;
- that the lowest chip select wins when segments overlap;
- the exact wrapped offset.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int UNIT_SHIFT = 23;
  localparam int UNIT_W     = 8;
  localparam int ADDR_W     = UNIT_SHIFT + UNIT_W;

  typedef logic [UNIT_W-1:0] unit_t;

  // Reset start unit of chip select idx: back-to-back layout from the base.
  function automatic unit_t dflt_start(int idx, int base, int first, int rest);
    if (idx == 0) return unit_t'(base);
    return unit_t'(base + first + (idx - 1) * rest);
  endfunction

  function automatic unit_t dflt_end(int idx, int base, int first, int rest);
    return unit_t'(int'(dflt_start(idx, base, first, rest)) + ((idx == 0) ? first : rest));
  endfunction

  function automatic logic is_pow2(unit_t v);
    return (v & (v - unit_t'(1))) == '0;
  endfunction
endpackage

// File: rtl/seg_reg_bank.sv
module seg_reg_bank #(
  parameter int NUM_CS    = 5,
  parameter int CS_W      = 3,
  parameter int BASE_UNIT = 64,
  parameter int CS0_UNITS = 8,
  parameter int CSN_UNITS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 commit,
  input  logic [CS_W-1:0]                      commit_cs,
  input  seg_pkg::unit_t                       commit_start,
  input  seg_pkg::unit_t                       commit_end,
  input  logic [CS_W-1:0]                      rd_cs,
  output logic [31:0]                          rd_data,
  output logic [NUM_CS-1:0][seg_pkg::UNIT_W-1:0] seg_start,
  output logic [NUM_CS-1:0][seg_pkg::UNIT_W-1:0] seg_end
);
  import seg_pkg::*;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
    localparam unit_t RST_START = dflt_start(g, BASE_UNIT, CS0_UNITS, CSN_UNITS);
    localparam unit_t RST_END   = dflt_end(g, BASE_UNIT, CS0_UNITS, CSN_UNITS);
    always_ff @(posedge clk) begin
      if (rst) begin
        seg_start[g] <= RST_START;
        seg_end[g]   <= RST_END;
      end else if (commit && commit_cs == CS_W'(g)) begin
        seg_start[g] <= commit_start;
        seg_end[g]   <= commit_end;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (rd_cs == CS_W'(i)) rd_mux = {seg_end[i], seg_start[i], 16'h0000};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/seg_wr_check.sv
module seg_wr_check #(
  parameter int NUM_CS    = 5,
  parameter int CS_W      = 3,
  parameter int BASE_UNIT = 64,
  parameter int WIN_UNITS = 32
) (
  input  logic                                   wr_en,
  input  logic [CS_W-1:0]                        wr_cs,
  input  logic [31:0]                            wr_data,
  input  logic [NUM_CS-1:0][seg_pkg::UNIT_W-1:0] seg_start,
  input  logic [NUM_CS-1:0][seg_pkg::UNIT_W-1:0] seg_end,
  output logic                                   commit,
  output seg_pkg::unit_t                         new_start,
  output seg_pkg::unit_t                         new_end,
  output logic                                   reject,
  output logic                                   misalign,
  output logic                                   overlap
);
  import seg_pkg::*;
  localparam int LIMIT_UNIT = BASE_UNIT + WIN_UNITS;

  unit_t raw_start, raw_end, cur_start, cur_end, eff_end, size_u;
  logic  cs_ok, same, outside, bad_align, act;
  logic [NUM_CS-1:0] hit;

  assign raw_end   = wr_data[31:24];
  assign raw_start = wr_data[23:16];
  assign cs_ok     = int'(wr_cs) < NUM_CS;

  always_comb begin
    cur_start = '0;
    cur_end   = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (wr_cs == CS_W'(i)) begin
        cur_start = seg_start[i];
        cur_end   = seg_end[i];
      end
  end

  assign same      = (raw_start == cur_start) && (raw_end == cur_end);
  assign new_start = (wr_cs == '0) ? unit_t'(BASE_UNIT) : raw_start;
  assign new_end   = raw_end;
  assign outside   = (int'(new_end) <= BASE_UNIT) || (int'(new_start) > LIMIT_UNIT);
  assign eff_end   = (new_end > new_start) ? new_end : new_start;
  assign size_u    = eff_end - new_start;
  assign bad_align = (size_u != '0) &&
                     (!is_pow2(size_u) || ((new_start & (size_u - unit_t'(1))) != '0));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ovl
    assign hit[g] = (wr_cs != CS_W'(g)) && (eff_end > seg_start[g]) && (new_start < seg_end[g]);
  end

  assign act      = wr_en && cs_ok && !same;
  assign commit   = act && !outside;
  assign reject   = act && outside;
  assign misalign = commit && bad_align;
  assign overlap  = commit && (|hit);
endmodule

// File: rtl/seg_decode.sv
module seg_decode #(
  parameter int NUM_CS = 5,
  parameter int CS_W   = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   dec_valid,
  input  logic                                   dec_direct,
  input  logic [CS_W-1:0]                        dec_cs,
  input  logic [seg_pkg::ADDR_W-1:0]             dec_addr,
  input  logic [NUM_CS-1:0][seg_pkg::UNIT_W-1:0] seg_start,
  input  logic [NUM_CS-1:0][seg_pkg::UNIT_W-1:0] seg_end,
  output logic                                   out_valid,
  output logic [CS_W-1:0]                        out_cs,
  output logic [seg_pkg::ADDR_W-1:0]             out_offset,
  output logic                                   out_miss,
  output logic                                   out_range
);
  import seg_pkg::*;

  unit_t a_unit, win_start, d_start, d_end, d_size;
  logic  win_hit, d_ok;
  logic [CS_W-1:0]   win_cs;
  logic [ADDR_W-1:0] d_bytes;
  logic [CS_W-1:0]   n_cs;
  logic [ADDR_W-1:0] n_off;
  logic              n_miss, n_range;

  assign a_unit = dec_addr[ADDR_W-1 -: UNIT_W];

  // Priority search: scan from the top so the lowest match is kept last.
  always_comb begin
    win_hit   = 1'b0;
    win_cs    = '0;
    win_start = '0;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (a_unit >= seg_start[i] && a_unit < seg_end[i]) begin
        win_hit   = 1'b1;
        win_cs    = CS_W'(i);
        win_start = seg_start[i];
      end
  end

  always_comb begin
    d_start = '0;
    d_end   = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (dec_cs == CS_W'(i)) begin
        d_start = seg_start[i];
        d_end   = seg_end[i];
      end
  end

  assign d_ok    = int'(dec_cs) < NUM_CS;
  assign d_size  = (d_end > d_start) ? (d_end - d_start) : '0;
  assign d_bytes = {d_size, {UNIT_SHIFT{1'b0}}};

  always_comb begin
    n_cs = '0; n_off = '0; n_miss = 1'b0; n_range = 1'b0;
    if (dec_direct) begin
      if (!d_ok) n_miss = 1'b1;
      else begin
        n_cs    = dec_cs;
        n_range = dec_addr >= d_bytes;
        n_off   = (d_size == '0) ? '0 : (dec_addr & (d_bytes - ADDR_W'(1)));
      end
    end else if (!win_hit) begin
      n_miss = 1'b1;
    end else begin
      n_cs  = win_cs;
      n_off = dec_addr - {win_start, {UNIT_SHIFT{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_cs <= '0; out_offset <= '0; out_miss <= 1'b0; out_range <= 1'b0;
    end else begin
      out_valid  <= dec_valid;
      out_cs     <= dec_valid ? n_cs    : '0;
      out_offset <= dec_valid ? n_off   : '0;
      out_miss   <= dec_valid && n_miss;
      out_range  <= dec_valid && n_range;
    end
  end
endmodule

// File: rtl/seg_window_decoder.sv
module seg_window_decoder #(
  parameter  int NUM_CS    = 5,
  parameter  int BASE_UNIT = 64,
  parameter  int WIN_UNITS = 32,
  parameter  int CS0_UNITS = 8,
  parameter  int CSN_UNITS = 4,
  localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int AW        = seg_pkg::ADDR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr_en,
  input  logic [CS_W-1:0] reg_wr_cs,
  input  logic [31:0]     reg_wr_data,
  input  logic [CS_W-1:0] reg_rd_cs,
  output logic [31:0]     reg_rd_data,
  output logic            wr_reject,
  output logic            wr_align_err,
  output logic            wr_overlap_err,
  input  logic            dec_valid,
  input  logic            dec_direct,
  input  logic [CS_W-1:0] dec_cs,
  input  logic [AW-1:0]   dec_addr,
  output logic            dec_out_valid,
  output logic [CS_W-1:0] dec_out_cs,
  output logic [AW-1:0]   dec_out_offset,
  output logic            dec_out_miss,
  output logic            dec_out_range
);
  import seg_pkg::*;

  logic [NUM_CS-1:0][UNIT_W-1:0] seg_start, seg_end;
  logic  commit, chk_reject, chk_align, chk_overlap;
  unit_t new_start, new_end;

  seg_wr_check #(.NUM_CS(NUM_CS), .CS_W(CS_W), .BASE_UNIT(BASE_UNIT), .WIN_UNITS(WIN_UNITS)) u_check (
    .wr_en(reg_wr_en), .wr_cs(reg_wr_cs), .wr_data(reg_wr_data),
    .seg_start(seg_start), .seg_end(seg_end),
    .commit(commit), .new_start(new_start), .new_end(new_end),
    .reject(chk_reject), .misalign(chk_align), .overlap(chk_overlap)
  );

  seg_reg_bank #(.NUM_CS(NUM_CS), .CS_W(CS_W), .BASE_UNIT(BASE_UNIT),
                 .CS0_UNITS(CS0_UNITS), .CSN_UNITS(CSN_UNITS)) u_bank (
    .clk(clk), .rst(rst), .commit(commit), .commit_cs(reg_wr_cs),
    .commit_start(new_start), .commit_end(new_end),
    .rd_cs(reg_rd_cs), .rd_data(reg_rd_data),
    .seg_start(seg_start), .seg_end(seg_end)
  );

  seg_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_direct(dec_direct),
    .dec_cs(dec_cs), .dec_addr(dec_addr), .seg_start(seg_start), .seg_end(seg_end),
    .out_valid(dec_out_valid), .out_cs(dec_out_cs), .out_offset(dec_out_offset),
    .out_miss(dec_out_miss), .out_range(dec_out_range)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_reject <= 1'b0; wr_align_err <= 1'b0; wr_overlap_err <= 1'b0;
    end else begin
      wr_reject      <= chk_reject;
      wr_align_err   <= chk_align;
      wr_overlap_err <= chk_overlap;
    end
  end
endmodule

// File: rtl/seg_window_decoder_chk.sv
module seg_window_decoder_chk #(
  parameter int NUM_CS    = 5,
  parameter int BASE_UNIT = 64,
  parameter int CS_W      = 3,
  parameter int AW        = 31
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr_en,
  input logic [CS_W-1:0] reg_rd_cs,
  input logic [31:0]     reg_rd_data,
  input logic            wr_reject,
  input logic            wr_align_err,
  input logic            wr_overlap_err,
  input logic            dec_valid,
  input logic            dec_direct,
  input logic            dec_out_valid,
  input logic [CS_W-1:0] dec_out_cs,
  input logic [AW-1:0]   dec_out_offset,
  input logic            dec_out_miss,
  input logic            dec_out_range
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  assert_rd_low_zero_R1: assert property (@(posedge clk) disable iff (rst || !past_ok)
    reg_rd_data[15:0] == 16'h0000);

  assert_cs0_start_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(reg_rd_cs) == '0) |-> (reg_rd_data[23:16] == BASE_UNIT[7:0]));

  assert_reject_alone_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
    wr_reject |-> (!wr_align_err && !wr_overlap_err));

  assert_flag_after_write_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (wr_reject || wr_align_err || wr_overlap_err) |-> $past(reg_wr_en));

  assert_window_no_range_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (dec_out_valid && !$past(dec_direct)) |-> !dec_out_range);

  assert_dec_latency_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    dec_out_valid == $past(dec_valid));

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (rst || !past_ok)
    dec_out_miss |-> (dec_out_cs == '0 && dec_out_offset == '0 && dec_out_valid));
endmodule

bind seg_window_decoder seg_window_decoder_chk #(
  .NUM_CS(NUM_CS), .BASE_UNIT(BASE_UNIT), .CS_W(CS_W), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_cs(reg_rd_cs),
  .reg_rd_data(reg_rd_data), .wr_reject(wr_reject), .wr_align_err(wr_align_err),
  .wr_overlap_err(wr_overlap_err), .dec_valid(dec_valid), .dec_direct(dec_direct),
  .dec_out_valid(dec_out_valid), .dec_out_cs(dec_out_cs), .dec_out_offset(dec_out_offset),
  .dec_out_miss(dec_out_miss), .dec_out_range(dec_out_range)
);

// File: tb/tb_seg_window_decoder.sv
module tb_seg_window_decoder;
  localparam int CS_W = 3;
  localparam int AW   = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [CS_W-1:0] reg_wr_cs = '0;
  logic [31:0] reg_wr_data = '0;
  logic [CS_W-1:0] reg_rd_cs = '0;
  logic [31:0] reg_rd_data;
  logic wr_reject, wr_align_err, wr_overlap_err;
  logic dec_valid = 1'b0, dec_direct = 1'b0;
  logic [CS_W-1:0] dec_cs = '0;
  logic [AW-1:0] dec_addr = '0;
  logic dec_out_valid, dec_out_miss, dec_out_range;
  logic [CS_W-1:0] dec_out_cs;
  logic [AW-1:0] dec_out_offset;

  always #10 clk = ~clk;

  seg_window_decoder dut (.*);

  typedef struct {
    int          kind;   // 0 write flags, 1 read data, 2 decode
    logic [31:0] data;
    logic [2:0]  flags;  // {reject, align, overlap}
    logic [2:0]  cs;
    logic [30:0] off;
    logic        miss;
    logic        rng;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit mon_on = 0, done = 0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic clear_inputs();
    reg_wr_en = 0; dec_valid = 0; dec_direct = 0;
  endtask

  task automatic do_write(logic [2:0] cs, logic [31:0] d, logic [2:0] fl, string tag);
    exp_t e;
    @(negedge clk); clear_inputs();
    reg_wr_en = 1; reg_wr_cs = cs; reg_wr_data = d;
    e = '{kind:0, data:0, flags:fl, cs:0, off:0, miss:0, rng:0, tag:tag};
    q.push_back(e);
  endtask

  task automatic do_read(logic [2:0] cs, logic [31:0] expd, string tag);
    exp_t e;
    @(negedge clk); clear_inputs();
    reg_rd_cs = cs;
    e = '{kind:1, data:expd, flags:0, cs:0, off:0, miss:0, rng:0, tag:tag};
    q.push_back(e);
  endtask

  task automatic do_dec(bit direct, logic [2:0] cs, logic [30:0] a,
                        logic [2:0] ecs, logic [30:0] eoff, bit emiss, bit erng, string tag);
    exp_t e;
    @(negedge clk); clear_inputs();
    dec_valid = 1; dec_direct = direct; dec_cs = cs; dec_addr = a;
    e = '{kind:2, data:0, flags:0, cs:ecs, off:eoff, miss:emiss, rng:erng, tag:tag};
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk); clear_inputs();
  endtask

  // Monitor: compare one expected item per clock, sampled mid-cycle.
  always @(posedge clk) begin
    int n;
    exp_t e;
    n = q.size();
    #5;
    if (mon_on) begin
      if (n > 0) begin
        e = q.pop_front();
        case (e.kind)
          0: check({wr_reject, wr_align_err, wr_overlap_err} == e.flags, e.tag,
                   {wr_reject, wr_align_err, wr_overlap_err}, e.flags);
          1: check(reg_rd_data == e.data, e.tag, reg_rd_data, e.data);
          default: check(dec_out_valid && dec_out_cs == e.cs && dec_out_offset == e.off &&
                         dec_out_miss == e.miss && dec_out_range == e.rng, e.tag,
                         {dec_out_valid, dec_out_miss, dec_out_range, dec_out_cs, dec_out_offset},
                         {1'b1, e.miss, e.rng, e.cs, e.off});
        endcase
      end else if (wr_reject || wr_align_err || wr_overlap_err || dec_out_valid) begin
        check(1'b0, "R6 spurious output", {wr_reject, wr_align_err, wr_overlap_err, dec_out_valid}, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #5;
    check(!wr_reject && !wr_align_err && !wr_overlap_err && !dec_out_valid && reg_rd_data == 0,
          "R8 reset outputs idle", {wr_reject, wr_align_err, wr_overlap_err, dec_out_valid}, 0);
    mon_on = 1;

    // Reset contents (R8, R1)
    do_read(0, 32'h4840_0000, "R8 cs0 default");
    do_read(1, 32'h4C48_0000, "R8 cs1 default");
    do_read(2, 32'h504C_0000, "R8 cs2 default");
    do_read(3, 32'h5450_0000, "R8 cs3 default");
    do_read(4, 32'h5854_0000, "R8 cs4 default");
    // Nonexistent index (R11)
    do_write(6, 32'h6460_0000, 3'b000, "R11 write to cs6 no flags");
    do_read(6, 32'h0, "R11 read cs6 zero");
    do_read(4, 32'h5854_0000, "R11 cs4 untouched");

    // Window decode (R9, R10)
    do_dec(0, 0, 31'h2000_0123, 0, 31'h123, 0, 0, "R9 cs0 hit");
    do_dec(0, 0, 31'h2500_0010, 1, 31'h0100_0010, 0, 0, "R9 cs1 hit");
    do_dec(0, 0, 31'h2B00_0000, 4, 31'h0100_0000, 0, 0, "R9 cs4 hit");
    do_dec(0, 0, 31'h3000_0000, 0, 0, 1, 0, "R10 window miss");
    // Direct (R7, R10)
    do_dec(1, 1, 31'h0200_0004, 1, 31'h4, 0, 1, "R7 direct wrap cs1");
    do_dec(1, 2, 31'h0000_0100, 2, 31'h100, 0, 0, "R7 direct in range cs2");
    do_dec(1, 7, 31'h0000_0100, 0, 0, 1, 0, "R10 direct bad cs");

    // cs0 start pinned, low bits dropped (R2, R1)
    do_write(0, 32'h4830_ABCD, 3'b000, "R2 cs0 write flags");
    do_read(0, 32'h4840_0000, "R2 R1 cs0 start pinned");

    // Rejects (R3)
    do_write(2, 32'h4038_0000, 3'b100, "R3 end at base rejected");
    do_read(2, 32'h504C_0000, "R3 cs2 unchanged");
    do_write(3, 32'h6261_0000, 3'b100, "R3 start beyond window rejected");
    do_read(3, 32'h5450_0000, "R3 cs3 unchanged");
    do_write(4, 32'h6460_0000, 3'b000, "R3 start at limit accepted");
    do_read(4, 32'h6460_0000, "R3 cs4 moved");
    do_dec(0, 0, 31'h3000_0000, 4, 0, 0, 0, "R9 new cs4 window hit");

    // Alignment (R4)
    do_write(3, 32'h5652_0000, 3'b010, "R4 misaligned start");
    do_read(3, 32'h5652_0000, "R4 misaligned stored");

    // Overlap (R5) and priority (R9)
    do_write(2, 32'h4844_0000, 3'b001, "R5 overlap with cs0");
    do_read(2, 32'h4844_0000, "R5 overlap stored");
    do_dec(0, 0, 31'h2280_0040, 0, 31'h0280_0040, 0, 0, "R9 lowest cs wins");

    // Equal write (R6)
    do_write(2, 32'h4844_0000, 3'b000, "R6 equal write no flags");

    // Non power of two size (R4)
    do_write(1, 32'h4B48_0000, 3'b010, "R4 size not power of two");
    do_read(1, 32'h4B48_0000, "R4 odd size stored");
    do_dec(0, 0, 31'h2400_0000, 1, 0, 0, 0, "R9 cs1 start");

    idle(); idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule